// File: doc/BRIEF.md
# Split Rename Register Free List

This block keeps the free physical register tags of a renaming out-of-order core. It holds two separate first-in first-out pools: one for integer tags and one for floating-point tags. Both classes use one shared tag numbering. Integer tags come first. Floating-point tags start right after the last integer tag.

The rename stage allocates from a pool and gets the oldest free tag in the same cycle it asks. Retirement logic can return a tag in two ways:
- A typed release port puts the tag straight into the named pool, with no checks.
- A generic release port first works out the pool from the tag's index. It drops tags that lie outside the physical range, and it drops tags that stand for hardwired zero registers.

Each pool reports whether it is non-empty and how many tags it holds. Sticky error flags catch two faults: an allocation from an empty pool, and a release that would overfill a pool (a double free). Reset loads each pool with the tags that have no architectural mapping.

Top module: `rename_free_pool`

## Requirements
- R1: After reset, the integer pool holds tags INT_ARCH up to INT_PHYS-1, in ascending order. The floating-point pool holds tags INT_PHYS+FP_ARCH up to INT_PHYS+FP_PHYS-1, in ascending order. The counts are INT_PHYS-INT_ARCH and FP_PHYS-FP_ARCH, and all error flags are 0.
- R2: A granted allocation returns the oldest tag in its pool and removes that tag. The grant and the tag are valid combinationally, in the same cycle as the request.
- R3: A typed release pushes its tag into the named pool with no range check and no zero filtering.
- R4: A generic release routes its tag as follows:
  - a tag below INT_PHYS goes to the integer pool;
  - a tag below INT_PHYS+FP_PHYS goes to the floating-point pool;
  - any higher tag is ignored.
- R5: A generic release drops the integer zero tag ZERO_REG. When FILTER_FP_ZERO is 1, it also drops ZERO_REG+INT_PHYS.
- R6: Each pool's nonempty output is 1 exactly when its count is not 0. The count equals the number of tags the pool holds.
- R7: An allocation request on an empty pool gives grant 0 and tag 0. It sets that pool's underflow flag, and the count stays 0.
- R8: A pool never holds more than its class's physical count of tags. A push that finds no room is dropped and sets that pool's overflow flag.
- R9: An allocation and a release on the same non-empty pool in the same cycle are both honoured, so the count does not change.
- R10: The underflow and overflow flags stay set until reset, and reset clears them.
- R11: When the typed port and the generic port push into the same pool in the same cycle, the typed tag is queued ahead of the generic tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_alloc_req | input | 1 | Request an integer tag |
| int_alloc_gnt | output | 1 | Integer request granted |
| int_alloc_tag | output | TAG_W | Granted integer tag (0 when not granted) |
| fp_alloc_req | input | 1 | Request a floating-point tag |
| fp_alloc_gnt | output | 1 | Floating-point request granted |
| fp_alloc_tag | output | TAG_W | Granted floating-point tag (0 when not granted) |
| int_free_vld | input | 1 | Typed integer release valid |
| int_free_tag | input | TAG_W | Tag for typed integer release |
| fp_free_vld | input | 1 | Typed floating-point release valid |
| fp_free_tag | input | TAG_W | Tag for typed floating-point release |
| any_free_vld | input | 1 | Generic release valid |
| any_free_tag | input | TAG_W | Tag for generic release, routed by index |
| int_nonempty | output | 1 | Integer pool holds at least one tag |
| int_count | output | CNT_W | Integer pool occupancy |
| fp_nonempty | output | 1 | Floating-point pool holds at least one tag |
| fp_count | output | CNT_W | Floating-point pool occupancy |
| int_underflow_err | output | 1 | Sticky: allocation from empty integer pool |
| fp_underflow_err | output | 1 | Sticky: allocation from empty floating-point pool |
| int_overflow_err | output | 1 | Sticky: push into full integer pool |
| fp_overflow_err | output | 1 | Sticky: push into full floating-point pool |

## Verification
The bench builds the block with these parameters:
- 8 integer tags, 4 of them architectural;
- 6 floating-point tags, 2 of them architectural;
- ZERO_REG 0 and FP zero filtering on.

With these values each pool drains to empty after four allocations and fills after a handful of releases. The floating-point depth of 6 is not a power of two, so its pointers wrap at a depth the bench reaches directly. Generic-release tags 0, 8 and anything from 14 upward fall in the drop cases, while tags 1–7 and 9–13 exercise both routing ranges.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_INT  = 2'd1,
        DEST_FP   = 2'd2
    } dest_e;

    typedef struct packed {
        logic  vld;
        dest_e dest;
    } route_t;

    // Pick the pool for a generically released tag; DEST_NONE drops it.
    function automatic dest_e classify(input int tag, input int int_phys,
                                       input int total, input int zero_reg,
                                       input bit filt_fp_zero);
        if (tag < int_phys)
            return (tag == zero_reg) ? DEST_NONE : DEST_INT;
        if (tag < total)
            return (filt_fp_zero && tag == zero_reg + int_phys) ? DEST_NONE : DEST_FP;
        return DEST_NONE;
    endfunction

    // Circular pointer advance for a depth that need not be a power of two.
    function automatic int wrap_add(input int ptr, input int step, input int depth);
        int s;
        s = ptr + step;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/fl_release_router.sv
module fl_release_router #(
    parameter int TAG_W          = 4,
    parameter int INT_PHYS       = 8,
    parameter int TOTAL          = 14,
    parameter int ZERO_REG       = 0,
    parameter int FILTER_FP_ZERO = 1
) (
    input  logic             rel_vld,
    input  logic [TAG_W-1:0] rel_tag,
    output logic             to_int,
    output logic             to_fp
);
    import fl_pkg::*;

    route_t route;

    always_comb begin
        route = '{vld: 1'b0, dest: DEST_NONE};
        if (rel_vld) begin
            route.dest = classify(int'(rel_tag), INT_PHYS, TOTAL, ZERO_REG,
                                  FILTER_FP_ZERO != 0);
            route.vld  = (route.dest != DEST_NONE);
        end
    end

    assign to_int = route.vld && (route.dest == DEST_INT);
    assign to_fp  = route.vld && (route.dest == DEST_FP);

endmodule

// File: rtl/fl_tag_pool.sv
module fl_tag_pool #(
    parameter int DEPTH     = 8,
    parameter int TAG_W     = 4,
    parameter int CNT_W     = 4,
    parameter int FIRST_TAG = 4,
    parameter int FILL      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop_req,
    output logic             pop_gnt,
    output logic [TAG_W-1:0] pop_tag,
    input  logic             push0_v,
    input  logic [TAG_W-1:0] push0_tag,
    input  logic             push1_v,
    input  logic [TAG_W-1:0] push1_tag,
    output logic             nonempty,
    output logic [CNT_W-1:0] count,
    output logic             underflow_err,
    output logic             overflow_err
);
    import fl_pkg::*;

    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WR_RESET = FILL % DEPTH;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, slot1;
    logic [CNT_W-1:0] cnt_q;
    logic             uflow_q, oflow_q;

    logic acc0, acc1, ovf_evt;
    int   room, n_push, cnt_nx;

    always_comb begin
        pop_gnt = pop_req && (cnt_q != '0);
        room    = DEPTH - int'(cnt_q) + (pop_gnt ? 1 : 0);
        acc0    = push0_v && (room >= 1);
        acc1    = push1_v && (room >= (acc0 ? 2 : 1));
        ovf_evt = (push0_v && !acc0) || (push1_v && !acc1);
        n_push  = (acc0 ? 1 : 0) + (acc1 ? 1 : 0);
        slot1   = acc0 ? PTR_W'(wrap_add(int'(wr_q), 1, DEPTH)) : wr_q;
        cnt_nx  = int'(cnt_q) - (pop_gnt ? 1 : 0) + n_push;
    end

    assign pop_tag       = pop_gnt ? mem[rd_q] : '0;
    assign nonempty      = (cnt_q != '0);
    assign count         = cnt_q;
    assign underflow_err = uflow_q;
    assign overflow_err  = oflow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i < FILL) ? TAG_W'(FIRST_TAG + i) : '0;
            rd_q    <= '0;
            wr_q    <= PTR_W'(WR_RESET);
            cnt_q   <= CNT_W'(FILL);
            uflow_q <= 1'b0;
            oflow_q <= 1'b0;
        end else begin
            if (acc0) mem[wr_q]  <= push0_tag;
            if (acc1) mem[slot1] <= push1_tag;
            if (pop_gnt) rd_q <= PTR_W'(wrap_add(int'(rd_q), 1, DEPTH));
            wr_q  <= PTR_W'(wrap_add(int'(wr_q), n_push, DEPTH));
            cnt_q <= CNT_W'(cnt_nx);
            if (pop_req && !pop_gnt) uflow_q <= 1'b1;
            if (ovf_evt)             oflow_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rename_free_pool.sv
module rename_free_pool #(
    parameter int INT_ARCH       = 32,
    parameter int INT_PHYS       = 64,
    parameter int FP_ARCH        = 32,
    parameter int FP_PHYS        = 64,
    parameter int ZERO_REG       = 0,
    parameter int FILTER_FP_ZERO = 1,
    localparam int TOTAL = INT_PHYS + FP_PHYS,
    localparam int TAG_W = $clog2(TOTAL),
    localparam int MAXP  = (INT_PHYS > FP_PHYS) ? INT_PHYS : FP_PHYS,
    localparam int CNT_W = $clog2(MAXP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_alloc_req,
    output logic             int_alloc_gnt,
    output logic [TAG_W-1:0] int_alloc_tag,
    input  logic             fp_alloc_req,
    output logic             fp_alloc_gnt,
    output logic [TAG_W-1:0] fp_alloc_tag,
    input  logic             int_free_vld,
    input  logic [TAG_W-1:0] int_free_tag,
    input  logic             fp_free_vld,
    input  logic [TAG_W-1:0] fp_free_tag,
    input  logic             any_free_vld,
    input  logic [TAG_W-1:0] any_free_tag,
    output logic             int_nonempty,
    output logic [CNT_W-1:0] int_count,
    output logic             fp_nonempty,
    output logic [CNT_W-1:0] fp_count,
    output logic             int_underflow_err,
    output logic             fp_underflow_err,
    output logic             int_overflow_err,
    output logic             fp_overflow_err
);
    // Index 0 = integer class, index 1 = floating-point class.
    logic [1:0]       alloc_req_a, alloc_gnt_a, typed_v_a, route_v_a;
    logic [1:0]       nonempty_a, uflow_a, oflow_a;
    logic [TAG_W-1:0] alloc_tag_a [2];
    logic [TAG_W-1:0] typed_tag_a [2];
    logic [CNT_W-1:0] count_a     [2];

    assign alloc_req_a    = {fp_alloc_req, int_alloc_req};
    assign typed_v_a      = {fp_free_vld, int_free_vld};
    assign typed_tag_a[0] = int_free_tag;
    assign typed_tag_a[1] = fp_free_tag;

    fl_release_router #(
        .TAG_W(TAG_W), .INT_PHYS(INT_PHYS), .TOTAL(TOTAL),
        .ZERO_REG(ZERO_REG), .FILTER_FP_ZERO(FILTER_FP_ZERO)
    ) u_router (
        .rel_vld (any_free_vld),
        .rel_tag (any_free_tag),
        .to_int  (route_v_a[0]),
        .to_fp   (route_v_a[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_pool
        localparam int DEPTH = (g == 0) ? INT_PHYS : FP_PHYS;
        localparam int ARCH  = (g == 0) ? INT_ARCH : FP_ARCH;
        localparam int BASE  = (g == 0) ? 0 : INT_PHYS;

        fl_tag_pool #(
            .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W),
            .FIRST_TAG(BASE + ARCH), .FILL(DEPTH - ARCH)
        ) u_pool (
            .clk           (clk),
            .rst           (rst),
            .pop_req       (alloc_req_a[g]),
            .pop_gnt       (alloc_gnt_a[g]),
            .pop_tag       (alloc_tag_a[g]),
            .push0_v       (typed_v_a[g]),
            .push0_tag     (typed_tag_a[g]),
            .push1_v       (route_v_a[g]),
            .push1_tag     (any_free_tag),
            .nonempty      (nonempty_a[g]),
            .count         (count_a[g]),
            .underflow_err (uflow_a[g]),
            .overflow_err  (oflow_a[g])
        );
    end

    assign int_alloc_gnt     = alloc_gnt_a[0];
    assign fp_alloc_gnt      = alloc_gnt_a[1];
    assign int_alloc_tag     = alloc_tag_a[0];
    assign fp_alloc_tag      = alloc_tag_a[1];
    assign int_nonempty      = nonempty_a[0];
    assign fp_nonempty       = nonempty_a[1];
    assign int_count         = count_a[0];
    assign fp_count          = count_a[1];
    assign int_underflow_err = uflow_a[0];
    assign fp_underflow_err  = uflow_a[1];
    assign int_overflow_err  = oflow_a[0];
    assign fp_overflow_err   = oflow_a[1];

endmodule

// File: rtl/fl_pool_checker.sv
module fl_pool_checker #(
    parameter int INT_ARCH       = 32,
    parameter int INT_PHYS       = 64,
    parameter int FP_ARCH        = 32,
    parameter int FP_PHYS        = 64,
    parameter int ZERO_REG       = 0,
    parameter int FILTER_FP_ZERO = 1,
    localparam int TOTAL = INT_PHYS + FP_PHYS,
    localparam int TAG_W = $clog2(TOTAL),
    localparam int MAXP  = (INT_PHYS > FP_PHYS) ? INT_PHYS : FP_PHYS,
    localparam int CNT_W = $clog2(MAXP + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             int_alloc_req,
    input logic             int_alloc_gnt,
    input logic             fp_alloc_req,
    input logic             int_free_vld,
    input logic             fp_free_vld,
    input logic             any_free_vld,
    input logic [TAG_W-1:0] any_free_tag,
    input logic             int_nonempty,
    input logic [CNT_W-1:0] int_count,
    input logic [CNT_W-1:0] fp_count,
    input logic             int_underflow_err,
    input logic             fp_overflow_err
);
    logic only_generic;
    assign only_generic = any_free_vld && !int_free_vld && !fp_free_vld &&
                          !int_alloc_req && !fp_alloc_req;

    AST_RESET_FILL: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (int_count == CNT_W'(INT_PHYS - INT_ARCH)) &&
                       (fp_count == CNT_W'(FP_PHYS - FP_ARCH)));                  // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int_count <= CNT_W'(INT_PHYS)) && (fp_count <= CNT_W'(FP_PHYS)));      // R8

    AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (int_alloc_req && !int_nonempty) |=> int_underflow_err);                // R7

    AST_EMPTY_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        (int_alloc_req && !int_nonempty) |-> !int_alloc_gnt);                   // R7

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        int_underflow_err |=> int_underflow_err);                               // R10

    AST_OFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        fp_overflow_err |=> fp_overflow_err);                                   // R10

    AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (int_alloc_gnt && int_free_vld && !any_free_vld) |=> $stable(int_count)); // R9

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (only_generic && int'(any_free_tag) >= TOTAL)
        |=> $stable(int_count) && $stable(fp_count));                           // R4

    AST_ZERO_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (only_generic && int'(any_free_tag) == ZERO_REG)
        |=> $stable(int_count));                                                // R5

endmodule

bind rename_free_pool fl_pool_checker #(
    .INT_ARCH(INT_ARCH), .INT_PHYS(INT_PHYS), .FP_ARCH(FP_ARCH),
    .FP_PHYS(FP_PHYS), .ZERO_REG(ZERO_REG), .FILTER_FP_ZERO(FILTER_FP_ZERO)
) u_chk (.*);

// File: tb/rename_free_pool_tb.sv
module rename_free_pool_tb;

    localparam int IA = 4, IP = 8, FA = 2, FP = 6, ZR = 0;
    localparam int TW = 4, CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ia = 0, fa = 0, iv = 0, fv = 0, gv = 0;
    logic [TW-1:0] it = '0, ft = '0, gt = '0;
    logic ig, fg, ine, fne, iu, fu, io, fo;
    logic [TW-1:0] itag, ftag;
    logic [CW-1:0] icnt, fcnt;

    int n_run = 0, n_fail = 0;

    // Scoreboard: expected contents of each pool and expected flags.
    logic [TW-1:0] exp_int_q[$];
    logic [TW-1:0] exp_fp_q[$];
    bit e_iu, e_fu, e_io, e_fo;

    always #4 clk = ~clk;

    rename_free_pool #(
        .INT_ARCH(IA), .INT_PHYS(IP), .FP_ARCH(FA), .FP_PHYS(FP),
        .ZERO_REG(ZR), .FILTER_FP_ZERO(1)
    ) u_dut (
        .clk(clk), .rst(rst),
        .int_alloc_req(ia), .int_alloc_gnt(ig), .int_alloc_tag(itag),
        .fp_alloc_req(fa), .fp_alloc_gnt(fg), .fp_alloc_tag(ftag),
        .int_free_vld(iv), .int_free_tag(it),
        .fp_free_vld(fv), .fp_free_tag(ft),
        .any_free_vld(gv), .any_free_tag(gt),
        .int_nonempty(ine), .int_count(icnt),
        .fp_nonempty(fne), .fp_count(fcnt),
        .int_underflow_err(iu), .fp_underflow_err(fu),
        .int_overflow_err(io), .fp_overflow_err(fo)
    );

    task automatic chk(input string lbl, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", lbl, what, act, exp);
        end
    endtask

    task automatic model_reset();
        exp_int_q.delete();
        exp_fp_q.delete();
        for (int i = IA; i < IP; i++) exp_int_q.push_back(TW'(i));
        for (int i = IP + FA; i < IP + FP; i++) exp_fp_q.push_back(TW'(i));
        e_iu = 0; e_fu = 0; e_io = 0; e_fo = 0;
    endtask

    task automatic push_int(input logic [TW-1:0] t);
        if (exp_int_q.size() < IP) exp_int_q.push_back(t); else e_io = 1;
    endtask

    task automatic push_fp(input logic [TW-1:0] t);
        if (exp_fp_q.size() < FP) exp_fp_q.push_back(t); else e_fo = 1;
    endtask

    task automatic check_state(input string lbl);
        chk(lbl, "int_count", int'(icnt), exp_int_q.size());
        chk(lbl, "fp_count", int'(fcnt), exp_fp_q.size());
        chk(lbl, "int_nonempty", int'(ine), int'(exp_int_q.size() != 0));
        chk(lbl, "fp_nonempty", int'(fne), int'(exp_fp_q.size() != 0));
        chk(lbl, "int_underflow", int'(iu), int'(e_iu));
        chk(lbl, "fp_underflow", int'(fu), int'(e_fu));
        chk(lbl, "int_overflow", int'(io), int'(e_io));
        chk(lbl, "fp_overflow", int'(fo), int'(e_fo));
    endtask

    // Driver: apply one cycle of stimulus, check the same-cycle grants,
    // then advance the scoreboard and compare the registered state.
    task automatic step(input string lbl, input bit a_i, input bit a_f,
                        input bit v_i, input int t_i, input bit v_f, input int t_f,
                        input bit v_g, input int t_g);
        @(negedge clk);
        ia = a_i; fa = a_f; iv = v_i; it = TW'(t_i);
        fv = v_f; ft = TW'(t_f); gv = v_g; gt = TW'(t_g);
        #1;
        if (a_i) begin
            chk(lbl, "int_alloc_gnt", int'(ig), int'(exp_int_q.size() != 0));
            chk(lbl, "int_alloc_tag", int'(itag),
                (exp_int_q.size() != 0) ? int'(exp_int_q[0]) : 0);
        end
        if (a_f) begin
            chk(lbl, "fp_alloc_gnt", int'(fg), int'(exp_fp_q.size() != 0));
            chk(lbl, "fp_alloc_tag", int'(ftag),
                (exp_fp_q.size() != 0) ? int'(exp_fp_q[0]) : 0);
        end
        @(posedge clk);
        if (a_i) begin
            if (exp_int_q.size() != 0) void'(exp_int_q.pop_front()); else e_iu = 1;
        end
        if (a_f) begin
            if (exp_fp_q.size() != 0) void'(exp_fp_q.pop_front()); else e_fu = 1;
        end
        if (v_i) push_int(TW'(t_i));
        if (v_f) push_fp(TW'(t_f));
        if (v_g) begin
            if (t_g < IP) begin
                if (t_g != ZR) push_int(TW'(t_g));
            end else if (t_g < IP + FP) begin
                if (t_g != ZR + IP) push_fp(TW'(t_g));
            end
        end
        #1;
        check_state(lbl);
    endtask

    task automatic idle(input string lbl);
        step(lbl, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ia = 0; fa = 0; iv = 0; fv = 0; gv = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        check_state("R1 reset fill");
        // R2: FIFO order of the reset fill, tag valid with the request.
        for (int k = 0; k < 4; k++) step("R2 int alloc order", 1, 0, 0, 0, 0, 0, 0, 0);
        // R7: allocation on an empty pool.
        step("R7 int alloc empty", 1, 0, 0, 0, 0, 0, 0, 0);
        idle("R10 underflow sticky");
        idle("R10 underflow sticky");
        // R3: typed releases bypass checks.
        step("R3 typed int zero", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R3 typed int fp-range tag", 0, 0, 1, 12, 0, 0, 0, 0);
        // R5: zero tags dropped on the generic port.
        step("R5 generic int zero", 0, 0, 0, 0, 0, 0, 1, 0);
        step("R5 generic fp zero", 0, 0, 0, 0, 0, 0, 1, 8);
        // R4: routing by index range.
        step("R4 generic to int", 0, 0, 0, 0, 0, 0, 1, 3);
        step("R4 generic to fp", 0, 0, 0, 0, 0, 0, 1, 9);
        step("R4 generic out of range", 0, 0, 0, 0, 0, 0, 1, 15);
        step("R4 generic out of range", 0, 0, 0, 0, 0, 0, 1, 14);
        step("R3 typed fp low tag", 0, 0, 0, 0, 1, 2, 0, 0);
        // Drain both pools, in order, with interleaving (R2, R6).
        for (int k = 0; k < 3; k++) step("R2 int drain", 1, 1, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R6 fp drain", 0, 1, 0, 0, 0, 0, 0, 0);
        // R11: typed ahead of generic in the same cycle.
        step("R11 dual push", 0, 0, 1, 5, 0, 0, 1, 6);
        step("R11 order first", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R11 order second", 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: allocate and release together.
        step("R9 seed", 0, 0, 1, 1, 0, 0, 0, 0);
        step("R9 swap", 1, 0, 1, 2, 0, 0, 0, 0);
        step("R9 after swap", 1, 0, 0, 0, 0, 0, 0, 0);
        // R8: fill floating-point pool, then overfill.
        for (int k = 8; k < 14; k++) step("R8 fp fill", 0, 0, 0, 0, 1, k, 0, 0);
        step("R8 fp overflow", 0, 0, 0, 0, 1, 10, 1, 9);
        idle("R10 overflow sticky");
        step("R8 dropped not queued", 0, 1, 0, 0, 0, 0, 0, 0);
        // R10/R1: reset clears flags and refills.
        do_reset();
        check_state("R10 reset clears flags");
        step("R1 first tag after reset", 1, 1, 0, 0, 0, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule